// File: doc/BRIEF.md
# Dual-Mode Asynchronous Host Bus Slave

This block connects an external host processor to an on-chip register port. The host bus has a 9-bit address, an 8-bit data path that the pad ring makes bidirectional using an output-enable from this block, an active-low chip select and two control pins. The host runs asynchronously to the block's clock. Each host read or write becomes exactly one single-cycle access on the internal register port. The block answers the host with an active-low ready acknowledge.

A static mode pin sets what the two control pins mean. In mode 0 the first pin selects the direction and the second is a data strobe. In mode 1 the first pin is a read strobe and the second is a write strobe. Every host pin, including the mode pin, goes through a two-stage register chain on the internal clock. No other synchronisation is applied. A faster internal clock therefore gives a shorter host response time.

Top module: `hbus_slave`

## Requirements
- R1: While reset is held and right after it is released, rdy_no is 1, data_oe_o is 0, and neither reg_we_o nor reg_re_o is asserted.
- R2: With mode_i=0, a transfer starts when ctl_b_i falls while cs_ni is 0. It is a read if ctl_a_i is 1 at that point and a write if ctl_a_i is 0.
- R3: With mode_i=1, a transfer starts when ctl_a_i falls (a read) or when ctl_b_i falls (a write), while cs_ni is 0. Both pins are active low.
- R4: While cs_ni is 1, strobe activity starts no transfer. No register pulse is issued, rdy_no stays 1 and data_oe_o stays 0.
- R5: A host write produces a reg_we_o pulse exactly one cycle long. During that pulse, reg_addr_o and reg_wdata_o carry the address and data the host presented with the strobe.
- R6: A host read produces a reg_re_o pulse exactly one cycle long, with reg_addr_o set to the host address. The byte returned on reg_rdata_i during that pulse is then presented on data_o.
- R7: Counting the first rising clock edge after the strobe becomes active as edge 1, rdy_no is still 1 after edge 3 and is 0 after edge 4.
- R8: Counting the first rising edge after the strobe is released as edge 1, data_oe_o is 0 after edge 2, rdy_no is still 0 after edge 2, and rdy_no is 1 after edge 3.
- R9: data_oe_o is 1 only while a read holds its result, with the chip select and the read strobe still asserted. It is never 1 for a write.
- R10: The read byte on data_o stays unchanged for as long as the strobe is held, even if reg_rdata_i changes after the access.
- R11: A strobe held active for any length of time produces exactly one register pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Control style: 0 = direction select plus strobe, 1 = separate strobes |
| cs_ni | input | 1 | Host chip select, active low |
| ctl_a_i | input | 1 | Mode 0: direction (1 = read). Mode 1: read strobe, active low |
| ctl_b_i | input | 1 | Mode 0: data strobe, active low. Mode 1: write strobe, active low |
| addr_i | input | 9 | Host address |
| data_i | input | 8 | Host write data from the pad |
| data_o | output | 8 | Read data to the pad |
| data_oe_o | output | 1 | Pad output-enable for data_o |
| rdy_no | output | 1 | Ready acknowledge, active low |
| reg_addr_o | output | 9 | Register port address |
| reg_wdata_o | output | 8 | Register port write data |
| reg_we_o | output | 1 | Register port write pulse |
| reg_re_o | output | 1 | Register port read pulse |
| reg_rdata_i | input | 8 | Register port read data |

## Verification
The bench drives host pins on the falling clock edge and samples outputs 1 ns after a rising edge, counting edges from each strobe change:
- The register pulse and its address are checked after edge 3.
- Ready low and the presented read byte are checked after edge 4.
- After the strobe is released, the output-enable is checked low after edge 2 and ready is checked high after edge 3.

Pulse counts are taken per transfer by a monitor, and a bench-owned register model is compared against an expected image. To test R10, the bench changes the read source while a read is being held.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned HBUS_AW = 9;
  localparam int unsigned HBUS_DW = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_HOLD
  } xfer_state_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode (
  input  logic mode_i,
  input  logic cs_ni,
  input  logic ctl_a_i,
  input  logic ctl_b_i,
  output logic req_o,
  output logic is_rd_o
);
  logic strobe;

  always_comb begin
    if (mode_i) begin
      // separate active-low strobes, read wins if both low
      strobe  = !ctl_a_i || !ctl_b_i;
      is_rd_o = !ctl_a_i;
    end else begin
      strobe  = !ctl_b_i;
      is_rd_o = ctl_a_i;
    end
    req_o = strobe && !cs_ni;
  end
endmodule

// File: rtl/hbus_xfer.sv
module hbus_xfer
  import hbus_pkg::*;
#(
  parameter int unsigned AW = HBUS_AW,
  parameter int unsigned DW = HBUS_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          is_rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_no
);
  xfer_state_e state_q, state_d;
  logic          req_q, start, rd_q, we_q, re_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, hold_q;

  assign start = (state_q == ST_IDLE) && req_i && !req_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_HOLD;
      ST_HOLD:   if (!req_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      rd_q    <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_i;
      we_q    <= start && !is_rd_i;
      re_q    <= start && is_rd_i;
      if (start) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        rd_q    <= is_rd_i;
      end
      if (state_q == ST_ACCESS && rd_q) hold_q <= rdata_i;
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
  assign data_o      = hold_q;
  assign rdy_no      = (state_q != ST_HOLD);
  assign data_oe_o   = (state_q == ST_HOLD) && rd_q && req_i;

  // R5
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R6
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  // R11
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  // R7
  rdy_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> $past(reg_we_o || reg_re_o));
  // R9
  oe_needs_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !rdy_no);
  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_no && $past(!rdy_no)) |-> $stable(data_o));
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int unsigned AW = HBUS_AW,
  parameter int unsigned DW = HBUS_DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cs_ni,
  input  logic          ctl_a_i,
  input  logic          ctl_b_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_no,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int unsigned SW = 4 + AW + DW;

  logic [SW-1:0] raw, syn;
  logic          mode_s, cs_ns, ctl_a_s, ctl_b_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          req, is_rd;

  assign raw = {mode_i, cs_ni, ctl_a_i, ctl_b_i, addr_i, data_i};

  hbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {mode_s, cs_ns, ctl_a_s, ctl_b_s, addr_s, data_s} = syn;

  hbus_decode i_decode (
    .mode_i (mode_s),
    .cs_ni  (cs_ns),
    .ctl_a_i(ctl_a_s),
    .ctl_b_i(ctl_b_s),
    .req_o  (req),
    .is_rd_o(is_rd)
  );

  hbus_xfer #(.AW(AW), .DW(DW)) i_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .is_rd_i    (is_rd),
    .addr_i     (addr_s),
    .wdata_i    (data_s),
    .rdata_i    (reg_rdata_i),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .rdy_no     (rdy_no)
  );

  // R4
  no_pulse_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ns && $past(cs_ns) && $past(cs_ns, 2) && rdy_no) |=> !(reg_we_o || reg_re_o));
endmodule

// File: tb/test_hbus_slave.sv
`timescale 1ns/1ps
module test_hbus_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, cs_n = 1'b1, ctl_a = 1'b1, ctl_b = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] data_o, reg_wdata_o, reg_rdata_i;
  logic       data_oe_o, rdy_no, reg_we_o, reg_re_o;
  logic [8:0] reg_addr_o;

  logic [7:0] mem [512];
  logic [7:0] expv [512];
  int n_tests = 0, n_fail = 0, we_cnt = 0, re_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  hbus_slave i_hbus_slave (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n),
    .ctl_a_i(ctl_a), .ctl_b_i(ctl_b), .addr_i(addr), .data_i(data),
    .data_o(data_o), .data_oe_o(data_oe_o), .rdy_no(rdy_no),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = mem[reg_addr_o];

  // register file model
  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_we_o) begin
        we_cnt <= we_cnt + 1;
        mem[reg_addr_o] <= reg_wdata_o;
      end
      if (reg_re_o) re_cnt <= re_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h5a;
  endfunction

  task automatic xfer(input bit md, input bit rd, input bit sel,
                      input logic [8:0] a, input logic [7:0] d, input int hold);
    int we0, re0;
    string mt;
    mt = md ? "R3" : "R2";
    @(negedge clk);
    mode = md; cs_n = !sel; ctl_a = 1'b1; ctl_b = 1'b1; addr = a; data = d;
    if (!md && !rd) ctl_a = 1'b0;
    repeat (3) @(negedge clk);
    we0 = we_cnt; re0 = re_cnt;
    if (!md) ctl_b = 1'b0;
    else if (rd) ctl_a = 1'b0;
    else ctl_b = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R7 rdy before edge4", rdy_no, 1);
    if (sel) begin
      check(rd ? "R6 re pulse" : "R5 we pulse", rd ? reg_re_o : reg_we_o, 1);
      check(rd ? "R6 addr" : "R5 addr", reg_addr_o, a);
      if (!rd) check("R5 wdata", reg_wdata_o, d);
    end
    @(posedge clk); #1;
    if (sel) begin
      check("R7 rdy low", rdy_no, 0);
      check("R9 oe", data_oe_o, rd);
      if (rd) check({mt, " read data"}, data_o, expv[a]);
    end else begin
      check("R4 rdy", rdy_no, 1);
      check("R4 oe", data_oe_o, 0);
    end
    for (int i = 0; i < hold; i++) begin
      if (i == 0 && rd && sel) mem[a] = ~mem[a];
      @(posedge clk); #1;
      if (sel && rd) check("R10 held data", data_o, expv[a]);
    end
    @(negedge clk);
    ctl_a = 1'b1; ctl_b = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R8 oe off", data_oe_o, 0);
    if (sel) check("R8 rdy still low", rdy_no, 0);
    @(posedge clk); #1;
    check("R8 rdy high", rdy_no, 1);
    if (sel) begin
      check("R11 pulses", rd ? (re_cnt - re0) : (we_cnt - we0), 1);
      check("R11 other", rd ? (we_cnt - we0) : (re_cnt - re0), 0);
      if (!rd) begin
        expv[a] = d;
        check({mt, " write stored"}, mem[a], d);
      end else begin
        mem[a] = expv[a];
      end
    end else begin
      check("R4 no pulses", (we_cnt - we0) + (re_cnt - re0), 0);
    end
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    for (int i = 0; i < 512; i++) begin
      mem[i] = init_val(i);
      expv[i] = init_val(i);
    end
    repeat (3) @(posedge clk); #1;
    check("R1 rdy in reset", rdy_no, 1);
    check("R1 oe in reset", data_oe_o, 0);
    check("R1 pulses in reset", {reg_we_o, reg_re_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R1 rdy after reset", rdy_no, 1);
    check("R1 pulses after reset", {reg_we_o, reg_re_o}, 0);

    // directed corners
    xfer(0, 1, 1, 9'h000, 8'h00, 0);
    xfer(0, 0, 1, 9'h1ff, 8'ha5, 2);
    xfer(0, 1, 1, 9'h1ff, 8'h00, 3);
    xfer(1, 0, 1, 9'h100, 8'h3c, 0);
    xfer(1, 1, 1, 9'h100, 8'h00, 4);
    xfer(1, 1, 1, 9'h0aa, 8'h00, 1);
    xfer(0, 0, 0, 9'h0aa, 8'hff, 1);
    xfer(1, 0, 0, 9'h0aa, 8'hee, 1);
    xfer(1, 1, 1, 9'h0aa, 8'h00, 1);

    for (int k = 0; k < 80; k++) begin
      xfer(1'($urandom), 1'($urandom), ($urandom % 8) != 0,
           9'($urandom), 8'($urandom), int'($urandom % 6));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule